// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block works out how many master-clock cycles fit into one word-clock (sample) period when the audio port is a slave, and reports which of six supported ratios is in use. The ratio code drives the clock-enable and filter sequencing elsewhere in the DAC. The block also reports whether the signal path runs at 64 or 128 times the sample rate. A separate watchdog notices when the master clock has stopped and raises a power-save request. The request drops as soon as the clock returns.

Both the master clock and the word clock arrive as asynchronous inputs. They are synchronised and edge-detected on a free-running reference clock, which also times the stall watchdog. A measurement is the number of master-clock rising edges between two word-clock rising edges. Each measurement is classified against the six ratios with a fixed tolerance. A new ratio is adopted only after two consecutive measurements agree on it.

Top module: `mclk_ratio_detect`

## Requirements
- R1: While reset is asserted, and on leaving it, ratioCode is 5, ratioMatched is 0, osr64 is 0 and powerSave is 0.
- R2: A measurement is the count of master-clock rising edges after one word-clock rising edge, up to and including the next one. The first word-clock rising edge after reset or after power-save only starts a measurement.
- R3: The ratio codes are 0 to 5 for 128, 192, 256, 384, 512 and 768 master clocks per sample, in that order. A measurement classifies to a ratio when it is at most 32 away from it, inclusive. Where two windows touch (a measurement of 160), the lower code wins.
- R4: A measurement outside every window classifies to code 5 (768). ratioMatched takes the result of the latest measurement: 1 when a window matched, 0 otherwise.
- R5: ratioCode takes a new value only when two consecutive measurements classify to that same code.
- R6: osr64 is 1 exactly when ratioCode is 0 or 1 (64x oversampling). Otherwise it is 0 (128x).
- R7: powerSave rises after STALL_CYCLES reference cycles (default 500, which is 5 us at 100 MHz) pass with no master-clock rising edge.
- R8: powerSave falls on the first master-clock rising edge after a stall. ratioCode and ratioMatched are held through power-save. A candidate waiting for its second measurement is discarded.
- R9: The period counter saturates at 2^CNT_W-1 (4095 by default) and never wraps. A period longer than that classifies as no match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mclkIn | input | 1 | Master clock, asynchronous |
| wclkIn | input | 1 | Word clock, asynchronous |
| ratioCode | output | 3 | Accepted ratio code, 0..5 |
| ratioMatched | output | 1 | Latest measurement fell inside a window |
| osr64 | output | 1 | 1: 64x oversampling, 0: 128x |
| powerSave | output | 1 | Master clock judged stopped |

## Verification
Two situations are hard to reach from the ports. The first is a stall that lands while a candidate ratio waits for its confirming measurement. The second is a period long enough to overflow the counter. The bench drives a master clock that it can gate. It locks one ratio, changes the period, and then stops the clock for longer than the watchdog limit. After the restart, the next single measurement must not change the ratio.

For overflow, the bench uses a period of 4352 master clocks. A wrapping counter would fold this onto 256 and report a valid code. A saturating counter reports a mismatch. The tolerance edges at 96, 95, 160, 224, 800 and 801 are also driven, with a behavioural model compared on every clock.

// File: rtl/mcrd_pkg.sv
package mcrd_pkg;
  localparam int NUM_RATIO = 6;
  localparam int CODE_W = 3;
  localparam logic [CODE_W-1:0] FALLBACK_CODE = 3'd5;

  // master clocks per sample period, ascending by code
  function automatic int ratioOf(input int idx);
    case (idx)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      default: return 768;
    endcase
  endfunction

  typedef struct packed {
    logic clearCount;    // hold period counter at zero
    logic restartCount;  // word-clock edge: start a new period
  } dpStrobe_t;
endpackage

// File: rtl/mcrd_sync_edge.sv
module mcrd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] shiftQ;
  logic prevQ;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) shiftQ[g] <= 1'b0;
          else       shiftQ[g] <= din;
      end else begin : gRest
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) shiftQ[g] <= 1'b0;
          else       shiftQ[g] <= shiftQ[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= shiftQ[STAGES-1];

  assign rise = shiftQ[STAGES-1] & ~prevQ;
endmodule

// File: rtl/mcrd_datapath.sv
module mcrd_datapath import mcrd_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int TOL = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkIn,
  input  logic              wclkIn,
  input  dpStrobe_t         strobe,
  output logic              mclkRise,
  output logic              wclkRise,
  output logic [CODE_W-1:0] measCode,
  output logic              measHit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int EXT_W = CNT_W + 2;

  logic [CNT_W-1:0] periodCnt;
  logic [CNT_W-1:0] measured;
  logic [NUM_RATIO-1:0] inWin;

  mcrd_sync_edge #(.STAGES(SYNC_STAGES)) uMclkSync (
    .clk(clk), .rstN(rstN), .din(mclkIn), .rise(mclkRise)
  );
  mcrd_sync_edge #(.STAGES(SYNC_STAGES)) uWclkSync (
    .clk(clk), .rstN(rstN), .din(wclkIn), .rise(wclkRise)
  );

  // a master edge coinciding with the word edge closes the current period
  assign measured = (mclkRise && periodCnt != CNT_MAX) ? periodCnt + 1'b1 : periodCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  periodCnt <= '0;
    else if (strobe.clearCount)                 periodCnt <= '0;
    else if (strobe.restartCount)               periodCnt <= '0;
    else if (mclkRise && periodCnt != CNT_MAX)  periodCnt <= periodCnt + 1'b1;
  end

  genvar i;
  generate
    for (i = 0; i < NUM_RATIO; i++) begin : gWin
      localparam int LO = (ratioOf(i) > TOL) ? ratioOf(i) - TOL : 0;
      localparam int HI = ratioOf(i) + TOL;
      assign inWin[i] = ({2'b00, measured} >= EXT_W'(LO)) &&
                        ({2'b00, measured} <= EXT_W'(HI));
    end
  endgenerate

  // lowest code wins where windows touch
  always_comb begin
    measCode = FALLBACK_CODE;
    measHit  = 1'b0;
    for (int k = NUM_RATIO - 1; k >= 0; k--) begin
      if (inWin[k]) begin
        measCode = CODE_W'(k);
        measHit  = 1'b1;
      end
    end
  end

  // R8: a clear strobe leaves the counter at zero
  p_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearCount |=> periodCnt == '0);
  // R9: saturated counter stays put until restarted
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (periodCnt == CNT_MAX && !strobe.clearCount && !strobe.restartCount) |=> periodCnt == CNT_MAX);
  // R2: counter moves only on master edges or word-clock restarts
  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clearCount && !strobe.restartCount && !mclkRise) |=> $stable(periodCnt));
endmodule

// File: rtl/mcrd_control.sv
module mcrd_control import mcrd_pkg::*; #(
  parameter int STALL_CYCLES = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mclkRise,
  input  logic              wclkRise,
  input  logic [CODE_W-1:0] measCode,
  input  logic              measHit,
  output dpStrobe_t         strobe,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioMatched,
  output logic              powerSave
);
  localparam int IDLE_W = $clog2(STALL_CYCLES + 1);
  localparam logic [IDLE_W-1:0] IDLE_LAST = IDLE_W'(STALL_CYCLES - 1);

  logic [IDLE_W-1:0] idleCnt;
  logic              armed;
  logic              pendValid;
  logic [CODE_W-1:0] pendCode;
  logic              stallNow;

  assign stallNow = !powerSave && !mclkRise && (idleCnt == IDLE_LAST);
  assign strobe.clearCount   = powerSave;
  assign strobe.restartCount = wclkRise & ~powerSave;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt      <= '0;
      armed        <= 1'b0;
      pendValid    <= 1'b0;
      pendCode     <= FALLBACK_CODE;
      ratioCode    <= FALLBACK_CODE;
      ratioMatched <= 1'b0;
      powerSave    <= 1'b0;
    end else if (powerSave) begin
      if (mclkRise) begin
        powerSave <= 1'b0;
        idleCnt   <= '0;
      end
    end else begin
      idleCnt <= mclkRise ? '0 : idleCnt + 1'b1;
      if (stallNow) begin
        powerSave <= 1'b1;
        armed     <= 1'b0;
        pendValid <= 1'b0;
      end else if (wclkRise) begin
        armed <= 1'b1;
        if (armed) begin
          ratioMatched <= measHit;
          pendCode     <= measCode;
          pendValid    <= 1'b1;
          if (pendValid && pendCode == measCode) ratioCode <= measCode;
        end
      end
    end
  end

  p_code_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    ratioCode <= FALLBACK_CODE);
  p_accept_two_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ratioCode != $past(ratioCode)) |-> ($past(pendValid) && $past(pendCode) == ratioCode));
  p_ps_exit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (powerSave && mclkRise) |=> !powerSave);
  p_ps_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    powerSave |=> ($stable(ratioCode) && $stable(ratioMatched)));
  p_no_stall_on_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!powerSave && mclkRise) |=> !powerSave);
  p_stall_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerSave) |-> $past(idleCnt) == IDLE_LAST);
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect import mcrd_pkg::*; #(
  parameter int CNT_W = 12,
  parameter int TOL = 32,
  parameter int SYNC_STAGES = 2,
  parameter int STALL_CYCLES = 500
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       mclkIn,
  input  logic       wclkIn,
  output logic [2:0] ratioCode,
  output logic       ratioMatched,
  output logic       osr64,
  output logic       powerSave
);
  dpStrobe_t         strobe;
  logic              mclkRise;
  logic              wclkRise;
  logic [CODE_W-1:0] measCode;
  logic              measHit;

  mcrd_datapath #(.CNT_W(CNT_W), .TOL(TOL), .SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(refClk), .rstN(rstN), .mclkIn(mclkIn), .wclkIn(wclkIn),
    .strobe(strobe), .mclkRise(mclkRise), .wclkRise(wclkRise),
    .measCode(measCode), .measHit(measHit)
  );

  mcrd_control #(.STALL_CYCLES(STALL_CYCLES)) uCtl (
    .clk(refClk), .rstN(rstN), .mclkRise(mclkRise), .wclkRise(wclkRise),
    .measCode(measCode), .measHit(measHit), .strobe(strobe),
    .ratioCode(ratioCode), .ratioMatched(ratioMatched), .powerSave(powerSave)
  );

  // codes 0 and 1 (128x, 192x) run the filters at 64x
  assign osr64 = (ratioCode <= 3'd1);
endmodule

// File: tb/tb_mclk_ratio_detect.sv
module tb_mclk_ratio_detect;
  localparam int STALL = 500;
  localparam int CMAX = 4095;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic mclkIn = 1'b0;
  logic wclkIn = 1'b0;
  logic [2:0] ratioCode;
  logic ratioMatched, osr64, powerSave;

  int checks = 0;
  int errors = 0;
  bit mclkRun = 0;
  bit cmpOn = 0;
  int divCnt = 0;
  int mcnt = 0;
  int periodLen = 128;

  mclk_ratio_detect dut (
    .refClk(refClk), .rstN(rstN), .mclkIn(mclkIn), .wclkIn(wclkIn),
    .ratioCode(ratioCode), .ratioMatched(ratioMatched), .osr64(osr64),
    .powerSave(powerSave)
  );

  always #5 refClk = ~refClk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // stimulus: master clock = refClk/4, word clock derived from master edges
  always @(negedge refClk) begin
    if (mclkRun) begin
      bit newM;
      divCnt++;
      newM = ((divCnt / 2) % 2) == 1;
      if (newM && !mclkIn) begin
        mcnt++;
        if (mcnt >= periodLen) begin
          mcnt = 0;
          wclkIn = 1'b1;
        end else if (mcnt == periodLen / 2) begin
          wclkIn = 1'b0;
        end
      end
      mclkIn = newM;
    end
  end

  // behavioural reference model
  int mq[$] = '{0, 0, 0};
  int lq[$] = '{0, 0, 0};
  int ratios[6] = '{128, 192, 256, 384, 512, 768};
  int mCnt, mIdle, mCode, mPendCode;
  bit mArmed, mPend, mHit, mPs;

  always @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      mq = '{0, 0, 0}; lq = '{0, 0, 0};
      mCnt = 0; mIdle = 0; mCode = 5; mPendCode = 5;
      mArmed = 0; mPend = 0; mHit = 0; mPs = 0;
    end else begin
      bit mr, lr;
      mr = (mq[1] == 1) && (mq[2] == 0);
      lr = (lq[1] == 1) && (lq[2] == 0);
      if (mPs) begin
        if (mr) begin mPs = 0; mIdle = 0; end
        mCnt = 0;
      end else begin
        int meas, code;
        bit hit, stallNow;
        meas = mCnt + (mr ? 1 : 0);
        if (meas > CMAX) meas = CMAX;
        code = 5; hit = 0;
        for (int i = 5; i >= 0; i--)
          if (meas >= ratios[i] - 32 && meas <= ratios[i] + 32) begin code = i; hit = 1; end
        stallNow = !mr && (mIdle == STALL - 1);
        mIdle = mr ? 0 : mIdle + 1;
        if (stallNow) begin
          mPs = 1; mArmed = 0; mPend = 0; mCnt = 0;
        end else if (lr) begin
          if (mArmed) begin
            mHit = hit;
            if (mPend && mPendCode == code) mCode = code;
            mPendCode = code; mPend = 1;
          end
          mArmed = 1; mCnt = 0;
        end else if (mr && mCnt < CMAX) begin
          mCnt++;
        end
      end
      mq.push_front(int'(mclkIn)); void'(mq.pop_back());
      lq.push_front(int'(wclkIn)); void'(lq.pop_back());
    end
  end

  // cycle-by-cycle comparison
  always @(negedge refClk) begin
    if (cmpOn) begin
      check("R5 model ratioCode", int'(ratioCode), mCode);
      check("R4 model ratioMatched", int'(ratioMatched), int'(mHit));
      check("R6 model osr64", int'(osr64), (mCode <= 1) ? 1 : 0);
      check("R7 model powerSave", int'(powerSave), int'(mPs));
    end
  end

  task automatic setLen(input int len, input int nMeas);
    @(posedge wclkIn);
    periodLen = len;
    repeat (nMeas) @(posedge wclkIn);
    repeat (4) @(negedge refClk);
  endtask

  task automatic lockExpect(input int len, input int code, input int hit, input string tag);
    setLen(len, 2);
    check({tag, " code"}, int'(ratioCode), code);
    check({tag, " matched"}, int'(ratioMatched), hit);
  endtask

  initial begin
    repeat (190000) @(posedge refClk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge refClk);
    // R1: reset values
    check("R1 reset ratioCode", int'(ratioCode), 5);
    check("R1 reset matched", int'(ratioMatched), 0);
    check("R1 reset osr64", int'(osr64), 0);
    check("R1 reset powerSave", int'(powerSave), 0);
    rstN = 1'b1;
    cmpOn = 1;
    @(negedge refClk);
    check("R1 after release ratioCode", int'(ratioCode), 5);
    mclkRun = 1;

    // R2/R3: first edge arms, then two periods lock
    lockExpect(128, 0, 1, "R3 ratio 128");
    check("R6 osr64 at 128", int'(osr64), 1);
    // R5: one measurement of a new ratio is not enough
    setLen(256, 1);
    check("R5 one period keeps code", int'(ratioCode), 0);
    check("R4 256 matched", int'(ratioMatched), 1);
    @(posedge wclkIn); repeat (4) @(negedge refClk);
    check("R5 second period accepts", int'(ratioCode), 2);
    check("R6 osr64 at 256", int'(osr64), 0);
    lockExpect(192, 1, 1, "R3 ratio 192");
    check("R6 osr64 at 192", int'(osr64), 1);
    lockExpect(384, 3, 1, "R3 ratio 384");
    check("R6 osr64 at 384", int'(osr64), 0);
    lockExpect(512, 4, 1, "R3 ratio 512");
    lockExpect(768, 5, 1, "R3 ratio 768");
    // tolerance edges
    lockExpect(96, 0, 1, "R3 low edge 96");
    lockExpect(95, 5, 0, "R4 below 95");
    lockExpect(160, 0, 1, "R3 tie 160");
    lockExpect(224, 1, 1, "R3 edge 224");
    lockExpect(417, 5, 0, "R4 gap 417");
    lockExpect(800, 5, 1, "R3 edge 800");
    lockExpect(801, 5, 0, "R4 over 801");
    // R9: saturation, a wrap would fold 4352 onto 256
    lockExpect(384, 3, 1, "R9 setup 384");
    lockExpect(4352, 5, 0, "R9 saturate");

    // R7/R8: stall handling
    lockExpect(256, 2, 1, "R8 setup 256");
    @(negedge refClk);
    mclkRun = 0;
    periodLen = 512;
    repeat (450) @(negedge refClk);
    check("R7 no early powerSave", int'(powerSave), 0);
    repeat (70) @(negedge refClk);
    check("R7 powerSave raised", int'(powerSave), 1);
    check("R8 code held in stall", int'(ratioCode), 2);
    check("R8 matched held in stall", int'(ratioMatched), 1);
    mclkRun = 1;
    repeat (10) @(negedge refClk);
    check("R8 powerSave cleared", int'(powerSave), 0);
    @(posedge wclkIn);
    @(posedge wclkIn); repeat (4) @(negedge refClk);
    check("R8 one period after stall keeps code", int'(ratioCode), 2);
    @(posedge wclkIn); repeat (4) @(negedge refClk);
    check("R8 relock after stall", int'(ratioCode), 4);

    cmpOn = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule